// File: doc/BRIEF.md
# Dual-Lane Serial Result Reader for a Simultaneous-Sampling Converter

This block sits on the host side of an eight-channel simultaneous-sampling converter and pulls the results of one conversion over the converter's serial port. When the companion `busy` input drops while the reader is idle, the reader pulls chip-select low and drives a divided serial clock. It shifts in two data lines at the same time. Line 0 carries channels 0 to 3 and line 1 carries channels 4 to 7, one 18-bit word after another on each line.

Each word is rebuilt MSB first and sent out on a valid/ready port, tagged with its channel number. Both lines finish a word on the same clock edge. The reader therefore parks those two words in a small stage and releases them one at a time. If that stage has not drained by the time the next word would begin, the serial clock is held high. The converter's first-data marker is checked at two fixed points of the frame, and a framing error is flagged when the marker is out of place.

Top module: `adc_dual_lane_reader`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 1, `out_valid` is 0 and `frame_err` is 0.
- R2: A 1-to-0 transition of `busy` while idle drives `cs_n` low at the next clock edge, with `sclk` still high. The first `sclk` falling edge follows after SCLK_HALF cycles and captures the MSB without any earlier edge.
- R3: Every low phase of `sclk` inside a frame lasts exactly SCLK_HALF clock cycles. A high phase lasts at least SCLK_HALF cycles.
- R4: Each line is sampled in the cycle in which `sclk` falls. 18 consecutive samples form one word: the first sample becomes bit 17 and the last becomes bit 0.
- R5: `sdo[0]` carries channels 0 to 3 and `sdo[1]` carries channels 4 to 7, in ascending order on each line. Words leave in the channel order 0,4,1,5,2,6,3,7, and `out_chan` holds the channel number.
- R6: A frame has exactly 72 falling edges of `sclk`. `cs_n` returns high on the rising edge that follows the 72nd fall, together with `sclk`.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_chan` keep their values. Each word is delivered exactly once.
- R8: While any word of the previous pair is still unaccepted, `sclk` is held high and does not fall into the first bit of a new word.
- R9: `frame_err` is set if `first_flag` is 0 at the first falling edge of a frame. It is cleared when the next frame starts.
- R10: `frame_err` is set if `first_flag` is still 1 at the 17th falling edge of a frame.
- R11: A falling edge of `busy` during a read is ignored. The frame completes normally and no second frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| busy | input | 1 | Conversion-in-progress indicator; its falling edge starts a read |
| sdo | input | LANES (2) | Serial data lines from the converter |
| first_flag | input | 1 | First-data marker from the converter |
| cs_n | output | 1 | Chip-select, active low |
| sclk | output | 1 | Serial clock; idles high |
| out_valid | output | 1 | Result word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | WORD_W (18) | Result word |
| out_chan | output | 3 | Channel number of `out_data` |
| frame_err | output | 1 | Framing error of the current or last frame |

## Verification
The clock divider can reach the point where `sclk` should fall into a new word's MSB in the same cycle that the consumer accepts the last parked word. The reader must still treat the stage as occupied for that cycle and delay the fall. The bench makes this collision happen by driving `out_ready` from a seeded random source, which is often sparse. At each word boundary it checks that `sclk` never fell while `out_valid` was high on the preceding sample. It also checks that all eight words arrive intact and in the correct order.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

   typedef enum logic {
      RD_IDLE  = 1'b0,
      RD_SHIFT = 1'b1
   } rd_state_e;

   // Counter width for a value range of n states (minimum one bit).
   function automatic int unsigned bits_for(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/sclk_div.sv
module sclk_div #(
   parameter int unsigned HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic hold,
   output logic sclk_o,
   output logic fall_stb,
   output logic rise_stb
);
   localparam int unsigned CW = sar_rd_pkg::bits_for(HALF);

   logic [CW-1:0] cnt;
   logic          sclk_q;
   logic          due;

   assign due      = (cnt == CW'(HALF - 1));
   assign fall_stb = run && due && sclk_q && !hold;
   assign rise_stb = run && due && !sclk_q;
   assign sclk_o   = sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         sclk_q <= 1'b1;
      end else if (!run) begin
         cnt    <= '0;
         sclk_q <= 1'b1;
      end else if (due) begin
         if (!(sclk_q && hold)) begin
            sclk_q <= ~sclk_q;
            cnt    <= '0;
         end
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   AST_NO_FALL_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (run && sclk_q && hold) |=> sclk_q); // R8

endmodule

// File: rtl/lane_shifter.sv
module lane_shifter #(
   parameter int unsigned WORD_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic              sdo,
   output logic [WORD_W-1:0] word_now
);
   logic [WORD_W-2:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sh <= '0;
      else if (cap) sh <= {sh[WORD_W-3:0], sdo};
   end

   // Completed word including the bit being sampled this cycle.
   assign word_now = {sh, sdo};

endmodule

// File: rtl/word_stage.sv
module word_stage #(
   parameter int unsigned LANES  = 2,
   parameter int unsigned WORD_W = 18,
   parameter int unsigned CH_W   = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    push,
   input  logic [LANES*WORD_W-1:0] push_words,
   input  logic [LANES*CH_W-1:0]   push_chans,
   output logic                    pend_any,
   output logic                    out_valid,
   input  logic                    out_ready,
   output logic [WORD_W-1:0]       out_data,
   output logic [CH_W-1:0]         out_chan
);
   localparam int unsigned LW = sar_rd_pkg::bits_for(LANES);

   logic [LANES-1:0]  vld;
   logic [WORD_W-1:0] dat [LANES];
   logic [CH_W-1:0]   chn [LANES];
   logic [LW-1:0]     sel;

   always_comb begin
      sel = '0;
      for (int i = LANES - 1; i >= 0; i--) begin
         if (vld[i]) sel = LW'(i);
      end
   end

   assign pend_any  = |vld;
   assign out_valid = pend_any;
   assign out_data  = dat[sel];
   assign out_chan  = chn[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= '0;
         for (int i = 0; i < LANES; i++) begin
            dat[i] <= '0;
            chn[i] <= '0;
         end
      end else if (push) begin
         for (int i = 0; i < LANES; i++) begin
            vld[i] <= 1'b1;
            dat[i] <= push_words[i*WORD_W +: WORD_W];
            chn[i] <= push_chans[i*CH_W +: CH_W];
         end
      end else if (out_valid && out_ready) begin
         vld[sel] <= 1'b0;
      end
   end

   AST_PUSH_INTO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !pend_any); // R8

   AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan))); // R7

endmodule

// File: rtl/adc_dual_lane_reader.sv
module adc_dual_lane_reader #(
   parameter int unsigned WORD_W      = 18,
   parameter int unsigned LANES       = 2,
   parameter int unsigned CH_PER_LANE = 4,
   parameter int unsigned SCLK_HALF   = 2,
   parameter int unsigned FLAG_DROP   = 16,
   localparam int unsigned CH_W       = sar_rd_pkg::bits_for(LANES * CH_PER_LANE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic [LANES-1:0]  sdo,
   input  logic              first_flag,
   output logic              cs_n,
   output logic              sclk,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_data,
   output logic [CH_W-1:0]   out_chan,
   output logic              frame_err
);
   import sar_rd_pkg::*;

   localparam int unsigned FRAME_FALLS = WORD_W * CH_PER_LANE;
   localparam int unsigned FC_W        = $clog2(FRAME_FALLS + 1);
   localparam int unsigned BC_W        = bits_for(WORD_W);
   localparam int unsigned GC_W        = bits_for(CH_PER_LANE);

   if (WORD_W < 3) begin : g_chk_word
      $error("WORD_W must be at least 3");
   end
   if (SCLK_HALF < 1) begin : g_chk_half
      $error("SCLK_HALF must be at least 1");
   end
   if (FLAG_DROP >= WORD_W) begin : g_chk_flag
      $error("FLAG_DROP must fall inside the first word");
   end

   rd_state_e         state;
   logic              busy_q;
   logic [FC_W-1:0]   fall_cnt;
   logic [BC_W-1:0]   bit_cnt;
   logic [GC_W-1:0]   grp;
   logic              err_q;

   logic              run, start, hold, last_bit, push, pend_any;
   logic              fall_stb, rise_stb;
   logic [LANES*WORD_W-1:0] lane_words;
   logic [LANES*CH_W-1:0]   lane_chans;

   assign run      = (state == RD_SHIFT);
   assign start    = (state == RD_IDLE) && busy_q && !busy;
   assign hold     = (bit_cnt == '0) && pend_any;
   assign last_bit = (bit_cnt == BC_W'(WORD_W - 1));
   assign push     = fall_stb && last_bit;
   assign cs_n     = !run;
   assign frame_err = err_q;

   sclk_div #(.HALF(SCLK_HALF)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .hold     (hold),
      .sclk_o   (sclk),
      .fall_stb (fall_stb),
      .rise_stb (rise_stb)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      lane_shifter #(.WORD_W(WORD_W)) u_sh (
         .clk      (clk),
         .rst_n    (rst_n),
         .cap      (fall_stb),
         .sdo      (sdo[l]),
         .word_now (lane_words[l*WORD_W +: WORD_W])
      );
      assign lane_chans[l*CH_W +: CH_W] = CH_W'(l * CH_PER_LANE) + CH_W'(grp);
   end

   word_stage #(.LANES(LANES), .WORD_W(WORD_W), .CH_W(CH_W)) u_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (push),
      .push_words (lane_words),
      .push_chans (lane_chans),
      .pend_any   (pend_any),
      .out_valid  (out_valid),
      .out_ready  (out_ready),
      .out_data   (out_data),
      .out_chan   (out_chan)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RD_IDLE;
         busy_q   <= 1'b0;
         fall_cnt <= '0;
         bit_cnt  <= '0;
         grp      <= '0;
         err_q    <= 1'b0;
      end else begin
         busy_q <= busy;
         case (state)
            RD_IDLE: begin
               if (start) begin
                  state    <= RD_SHIFT;
                  fall_cnt <= '0;
                  bit_cnt  <= '0;
                  grp      <= '0;
                  err_q    <= 1'b0;
               end
            end
            RD_SHIFT: begin
               if (fall_stb) begin
                  if (fall_cnt == '0 && !first_flag) err_q <= 1'b1;
                  if (fall_cnt == FC_W'(FLAG_DROP) && first_flag) err_q <= 1'b1;
                  fall_cnt <= fall_cnt + 1'b1;
                  if (last_bit) begin
                     bit_cnt <= '0;
                     grp     <= grp + 1'b1;
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
               if (rise_stb && fall_cnt == FC_W'(FRAME_FALLS)) state <= RD_IDLE;
            end
            default: state <= RD_IDLE;
         endcase
      end
   end

   AST_START_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> sclk); // R2

   AST_RELEASE_AFTER_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> ($past(fall_cnt) == FC_W'(FRAME_FALLS))); // R6

   AST_FALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (fall_cnt <= FC_W'(FRAME_FALLS))); // R6

   AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> !frame_err); // R9

endmodule

// File: tb/sim_adc_dual_lane_reader.sv
`timescale 1ns/1ps
module sim_adc_dual_lane_reader;
   localparam int WORD_W = 18;
   localparam int LANES  = 2;
   localparam int HALF   = 2;
   localparam int NCH    = 8;
   localparam int FALLS  = 72;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic busy = 1'b0;
   logic [LANES-1:0] sdo;
   logic first_flag;
   logic cs_n, sclk, out_valid, frame_err;
   logic out_ready = 1'b0;
   logic [WORD_W-1:0] out_data;
   logic [2:0] out_chan;

   always #2 clk = ~clk;

   adc_dual_lane_reader #(.SCLK_HALF(HALF)) u0 (
      .clk(clk), .rst_n(rst_n), .busy(busy), .sdo(sdo), .first_flag(first_flag),
      .cs_n(cs_n), .sclk(sclk), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_chan(out_chan), .frame_err(frame_err)
   );

   int n_tests = 0;
   int n_fail  = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // ---------------- converter model ----------------
   logic [FALLS-1:0] strm_a, strm_b;
   bit flag_low_mode = 0, flag_stuck_mode = 0;
   int fall_n = 0;
   int bit_at, idx;

   always @(negedge sclk or negedge cs_n) begin
      if (sclk) fall_n = 0;
      else if (!cs_n) fall_n = fall_n + 1;
   end

   assign bit_at = sclk ? fall_n : fall_n - 1;
   assign idx    = (bit_at > FALLS - 1) ? FALLS - 1 : ((bit_at < 0) ? 0 : bit_at);
   assign sdo    = cs_n ? 2'b00 : {strm_b[FALLS-1-idx], strm_a[FALLS-1-idx]};
   assign first_flag = !cs_n && !flag_low_mode && (fall_n < 16 || flag_stuck_mode);

   // ---------------- expectations ----------------
   logic [WORD_W-1:0] exp_w [NCH];

   function automatic int exp_chan(input int k);
      return (k % 2 == 0) ? k / 2 : k / 2 + 4;
   endfunction

   // ---------------- consumer and phase monitors ----------------
   int rdy_mode = 0;
   int got = 0;
   int low_len = 0, low_bad = 0, hold_bad = 0;
   logic prev_sclk = 1'b1, prev_valid = 1'b0;

   always @(negedge clk) begin
      bit r;
      int c;
      case (rdy_mode)
         0:       r = 1'b1;
         1:       r = ($urandom % 2) == 0;
         default: r = ($urandom % 6) == 0;
      endcase
      if (rst_n && out_valid && r) begin
         if (got < NCH) begin
            c = exp_chan(got);
            check(out_chan == 3'(c), "R5", "channel order", 32'(out_chan), 32'(c));
            check(out_data == exp_w[c], "R4", "word value", 32'(out_data), 32'(exp_w[c]));
         end else begin
            check(1'b0, "R7", "extra word", 32'(got + 1), 32'(NCH));
         end
         got++;
      end
      out_ready = r;
      if (!cs_n) begin
         if (!sclk) low_len++;
         else if (low_len != 0) begin
            if (low_len != HALF) low_bad++;
            low_len = 0;
         end
      end else low_len = 0;
      if (!cs_n && prev_sclk && !sclk && fall_n > 1 && ((fall_n - 1) % WORD_W) == 0 && prev_valid)
         hold_bad++;
      prev_sclk  = sclk;
      prev_valid = out_valid;
   end

   // ---------------- one frame ----------------
   task automatic run_frame(input int rmode, input bit lowf, input bit stuck, input bit midbusy);
      int lim;
      strm_a = {exp_w[0], exp_w[1], exp_w[2], exp_w[3]};
      strm_b = {exp_w[4], exp_w[5], exp_w[6], exp_w[7]};
      flag_low_mode = lowf;
      flag_stuck_mode = stuck;
      rdy_mode = rmode;
      got = 0; low_bad = 0; hold_bad = 0;
      @(negedge clk) busy = 1'b1;
      repeat (3) @(negedge clk);
      busy = 1'b0;
      @(negedge clk);
      check(cs_n == 1'b0 && sclk == 1'b1, "R2", "cs low with sclk high", {cs_n, sclk}, 32'b01);
      if (midbusy) begin
         repeat (20) @(negedge clk);
         busy = 1'b1;
         repeat (2) @(negedge clk);
         busy = 1'b0;
      end
      lim = 0;
      while (!cs_n && lim < 20000) begin @(negedge clk); lim++; end
      check(fall_n == FALLS, "R6", "falls per frame", 32'(fall_n), 32'(FALLS));
      check(frame_err == (lowf | stuck), stuck ? "R10" : "R9", "frame_err",
            32'(frame_err), 32'(lowf | stuck));
      lim = 0;
      while (got < NCH && lim < 20000) begin @(negedge clk); lim++; end
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (cs_n == 1'b0) begin
            check(1'b0, "R11", "spurious restart", 32'(cs_n), 32'(1));
            i = 10;
         end
      end
      check(got == NCH, "R7", "words delivered", 32'(got), 32'(NCH));
      check(low_bad == 0, "R3", "low phase length errors", 32'(low_bad), 32'(0));
      check(hold_bad == 0, "R8", "fall into new word while pending", 32'(hold_bad), 32'(0));
      if (midbusy) check(fall_n == FALLS && got == NCH, "R11", "read unaffected by busy", 32'(got), 32'(NCH));
      rdy_mode = 0;
   endtask

   task automatic fill_random();
      for (int i = 0; i < NCH; i++) exp_w[i] = WORD_W'($urandom);
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(cs_n == 1'b1, "R1", "cs_n after reset", 32'(cs_n), 32'(1));
      check(sclk == 1'b1, "R1", "sclk after reset", 32'(sclk), 32'(1));
      check(out_valid == 1'b0 && frame_err == 1'b0, "R1", "valid/err after reset",
            {out_valid, frame_err}, 32'(0));

      exp_w[0] = 18'h3FFFF; exp_w[1] = 18'h00000; exp_w[2] = 18'h2AAAA; exp_w[3] = 18'h15555;
      exp_w[4] = 18'h20000; exp_w[5] = 18'h00001; exp_w[6] = 18'h1FFFF; exp_w[7] = 18'h3FFFE;
      run_frame(0, 0, 0, 0);
      fill_random(); run_frame(2, 0, 0, 0);
      fill_random(); run_frame(0, 1, 0, 0);
      fill_random(); run_frame(1, 0, 0, 0);
      fill_random(); run_frame(0, 0, 1, 0);
      fill_random(); run_frame(0, 0, 0, 1);
      for (int f = 0; f < 8; f++) begin
         fill_random();
         run_frame(int'($urandom % 3), 0, 0, 0);
      end
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired (R6): actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule